// File: doc/BRIEF.md
# Round-Robin Serial Lane Distributor

The block accepts 44-bit hit words over a valid/ready handshake and hands each accepted word, whole, to one of several serial output lanes, stepping through the lanes in strict rotation. Each lane keeps a small word buffer of its own. The word is zero-extended to 48 bits and leaves its lane as six bytes, most significant byte first. Every byte is 8b/10b encoded against that lane's running disparity and then shifted out one bit at a time. A lane with nothing to send fills the line with K28.5 comma symbols, so a receiver can keep bit and symbol lock.

All logic runs on the fast bit clock. A two-bit rate select sets how many clocks each serial bit is held. At the full rate the clock is carried inside the encoded stream and the forwarded clock output stays low. At the divided rates that output toggles once per bit, so the receiver can latch data on its rising edge. An almost-full flag warns the upstream logic before any lane buffer runs out of room.

Top module: `rr_lane_distributor`

## Requirements
- R1: While rst_ni is low, ready_o is 1, almost_full_o is 0, every ser_data_o bit is 0 and ser_clk_o is 0.
- R2: The n-th word accepted since reset (counting from 0) is sent on lane n mod LANES. A word is accepted on a clock edge where valid_i and ready_o are both high.
- R3: An accepted word is sent on its lane as six consecutive data symbols. Byte k (k = 0..5) is bits [47-8k : 40-8k] of the word with four zero bits added above bit 43.
- R4: Each byte is encoded with the standard 8b/10b code. Running disparity starts negative at reset and is updated after every symbol, including commas. The 10-bit symbol is sent abcdei first, then fghj, with bit a first on the line.
- R5: At a symbol boundary, a lane whose buffer is empty and which is not partway through a word sends K28.5: 0011111010 at negative disparity and 1100000101 at positive disparity. The first symbol after reset is 0011111010.
- R6: With rate_i = r, each serial bit is held for 2^r clocks. All lanes change bits on the same clock edges and begin symbols on the same edges.
- R7: ser_clk_o is 0 when rate_i = 0. For rate_i > 0 it is low during the first half of each bit period and high during the second half.
- R8: ready_o is low exactly when the buffer of the lane due to receive the next word holds DEPTH words. While ready_o is low no word is taken and the lane rotation does not advance.
- R9: almost_full_o is high whenever any lane buffer holds DEPTH-1 or more words, that is, when it has fewer than two free slots.
- R10: A word stays in its lane buffer until its last byte begins transmission. At the slowest rate, a stream of words offered back to back from reset is accepted LANES*DEPTH times before ready_o first drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_i | input | 2 | Bit period select: 2^rate_i clocks per bit; 0 selects embedded-clock mode |
| word_i | input | 44 | Hit word |
| valid_i | input | 1 | word_i is offered |
| ready_o | output | 1 | The target lane can take a word |
| almost_full_o | output | 1 | Some lane buffer has fewer than two free slots |
| ser_data_o | output | 8 | Serial data, one bit per lane |
| ser_clk_o | output | 1 | Forwarded bit clock in divided-rate modes |

## Verification
On every cycle the assertions check that the lane rotation advances only on a handshake and wraps correctly, that a full target lane blocks ready_o, and that a blocked input always comes with almost_full_o. They also check that no lane buffer count goes past its depth, that the serial outputs change only on bit ticks, and that the forwarded clock is quiet at the full rate. The bench alone can show that the symbols are correct: the byte order, the 8b/10b codes and the disparity chain on each lane, the comma fill, and the exact moment a word leaves its buffer. It does this with a behavioural model that predicts every lane bit at each of the four rates.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  localparam logic [9:0] COMMA_NEG = 10'b0011111010;
  localparam logic [9:0] COMMA_POS = 10'b1100000101;

  // 5b/6b codes for negative running disparity, abcdei order
  function automatic logic [5:0] map6(input logic [4:0] x);
    logic [5:0] c;
    case (x)
      5'd0:  c = 6'b100111;  5'd1:  c = 6'b011101;  5'd2:  c = 6'b101101;  5'd3:  c = 6'b110001;
      5'd4:  c = 6'b110101;  5'd5:  c = 6'b101001;  5'd6:  c = 6'b011001;  5'd7:  c = 6'b111000;
      5'd8:  c = 6'b111001;  5'd9:  c = 6'b100101;  5'd10: c = 6'b010101;  5'd11: c = 6'b110100;
      5'd12: c = 6'b001101;  5'd13: c = 6'b101100;  5'd14: c = 6'b011100;  5'd15: c = 6'b010111;
      5'd16: c = 6'b011011;  5'd17: c = 6'b100011;  5'd18: c = 6'b010011;  5'd19: c = 6'b110010;
      5'd20: c = 6'b001011;  5'd21: c = 6'b101010;  5'd22: c = 6'b011010;  5'd23: c = 6'b111010;
      5'd24: c = 6'b110011;  5'd25: c = 6'b100110;  5'd26: c = 6'b010110;  5'd27: c = 6'b110110;
      5'd28: c = 6'b001110;  5'd29: c = 6'b101110;  5'd30: c = 6'b011110;  default: c = 6'b101011;
    endcase
    return c;
  endfunction

  // 3b/4b primary codes for negative disparity, fghj order
  function automatic logic [3:0] map4(input logic [2:0] y);
    logic [3:0] c;
    case (y)
      3'd0: c = 4'b1011; 3'd1: c = 4'b1001; 3'd2: c = 4'b0101; 3'd3: c = 4'b1100;
      3'd4: c = 4'b1101; 3'd5: c = 4'b1010; 3'd6: c = 4'b0110; default: c = 4'b1110;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rrd_enc.sv
module rrd_enc (
  input  logic [7:0] byte_i,
  input  logic       comma_i,
  input  logic       rd_i,
  output logic [9:0] sym_o,
  output logic       rd_o
);
  import rrd_pkg::*;

  logic [4:0] x_w;
  logic [2:0] y_w;
  logic [5:0] c6_w, s6_w;
  logic [3:0] c4_w, s4_w;
  logic       d6_w, d4_w, rd_mid_w, alt7_w;

  assign x_w = byte_i[4:0];
  assign y_w = byte_i[7:5];

  always_comb begin
    c6_w     = map6(x_w);
    d6_w     = ($countones(c6_w) != 3);
    s6_w     = (rd_i && (d6_w || x_w == 5'd7)) ? ~c6_w : c6_w;
    rd_mid_w = rd_i ^ d6_w;
    // alternate x.7 form avoids a run of five equal bits
    alt7_w   = (y_w == 3'd7) &&
               ((!rd_mid_w && (x_w == 5'd17 || x_w == 5'd18 || x_w == 5'd20)) ||
                ( rd_mid_w && (x_w == 5'd11 || x_w == 5'd13 || x_w == 5'd14)));
    c4_w     = alt7_w ? 4'b0111 : map4(y_w);
    d4_w     = ($countones(c4_w) != 2);
    s4_w     = (rd_mid_w && (d4_w || y_w == 3'd3)) ? ~c4_w : c4_w;
    if (comma_i) begin
      sym_o = rd_i ? COMMA_POS : COMMA_NEG;
      rd_o  = ~rd_i;
    end else begin
      sym_o = {s6_w, s4_w};
      rd_o  = rd_mid_w ^ d4_w;
    end
  end
endmodule

// File: rtl/rrd_fifo.sv
module rrd_fifo #(
  parameter int W     = 44,
  parameter int DEPTH = 4,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [AW-1:0] inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= inc(wp_q);
      if (pop_i)  rp_q <= inc(rp_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign dout_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rrd_dispatch.sv
module rrd_dispatch #(
  parameter int LANES = 8,
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [LANES-1:0] full_i,
  output logic             ready_o,
  output logic [LANES-1:0] push_o,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q;
  logic             take_w;

  assign ready_o = ~full_i[ptr_q];
  assign take_w  = valid_i && ready_o;
  assign push_o  = take_w ? (LANES'(1) << ptr_q) : '0;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (take_w) ptr_q <= (ptr_q == PTR_W'(LANES - 1)) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/rrd_lane_tx.sv
module rrd_lane_tx #(
  parameter int WORD_W = 44,
  localparam int BYTES = (WORD_W + 7) / 8,
  localparam int PAD_W = BYTES * 8,
  localparam int BI_W  = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              empty_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pop_o,
  output logic              ser_o
);
  logic [9:0]      sh_q, sym_w;
  logic [3:0]      bcnt_q;
  logic [BI_W-1:0] bidx_q;
  logic            rd_q, rd_w, is_comma_w, load_w, last_w;
  logic [PAD_W-1:0] pad_w, shifted_w;
  logic [7:0]      byte_w;

  assign pad_w      = PAD_W'(word_i);
  assign shifted_w  = pad_w << (bidx_q * 8);
  assign byte_w     = shifted_w[PAD_W-1 -: 8];
  assign is_comma_w = empty_i && (bidx_q == '0);
  assign load_w     = tick_i && (bcnt_q == 4'd9);
  assign last_w     = (bidx_q == BI_W'(BYTES - 1));
  assign pop_o      = load_w && !is_comma_w && last_w;
  assign ser_o      = sh_q[9];

  rrd_enc u_enc (
    .byte_i (byte_w),
    .comma_i(is_comma_w),
    .rd_i   (rd_q),
    .sym_o  (sym_w),
    .rd_o   (rd_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= 4'd9;
      rd_q   <= 1'b0;
      bidx_q <= '0;
    end else if (tick_i) begin
      if (bcnt_q == 4'd9) begin
        sh_q   <= sym_w;
        bcnt_q <= '0;
        rd_q   <= rd_w;
        if (!is_comma_w) bidx_q <= last_w ? '0 : bidx_q + 1'b1;
      end else begin
        sh_q   <= {sh_q[8:0], 1'b0};
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_lane_distributor.sv
module rr_lane_distributor #(
  parameter int WORD_W = 44,
  parameter int LANES  = 8,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        rate_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              almost_full_o,
  output logic [LANES-1:0]  ser_data_o,
  output logic              ser_clk_o
);
  logic [2:0]                  div_q, mask_w;
  logic                        tick;
  logic [LANES-1:0]            push, full, empty, pop;
  logic [LANES-1:0][CNT_W-1:0] lane_cnt;
  logic [PTR_W-1:0]            wr_lane;

  // shared bit-period divider keeps all lanes symbol aligned
  assign mask_w = 3'((4'd1 << rate_i) - 4'd1);
  assign tick   = ((div_q & mask_w) == mask_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  always_comb begin
    case (rate_i)
      2'd0:    ser_clk_o = 1'b0;
      2'd1:    ser_clk_o = div_q[0];
      2'd2:    ser_clk_o = div_q[1];
      default: ser_clk_o = div_q[2];
    endcase
  end

  rrd_dispatch #(.LANES(LANES)) u_disp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .full_i (full),
    .ready_o(ready_o),
    .push_o (push),
    .ptr_o  (wr_lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [WORD_W-1:0] head;

    rrd_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .push_i (push[g]),
      .din_i  (word_i),
      .pop_i  (pop[g]),
      .dout_o (head),
      .empty_o(empty[g]),
      .full_o (full[g]),
      .cnt_o  (lane_cnt[g])
    );

    rrd_lane_tx #(.WORD_W(WORD_W)) u_tx (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick),
      .empty_i(empty[g]),
      .word_i (head),
      .pop_o  (pop[g]),
      .ser_o  (ser_data_o[g])
    );
  end

  always_comb begin
    almost_full_o = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (lane_cnt[i] >= CNT_W'(DEPTH - 1)) almost_full_o = 1'b1;
  end
endmodule

// File: rtl/rr_lane_distributor_chk.sv
module rr_lane_distributor_chk #(
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [1:0]                  rate_i,
  input logic                        valid_i,
  input logic                        ready_i,
  input logic                        af_i,
  input logic [LANES-1:0]            ser_i,
  input logic                        ser_clk_i,
  input logic                        tick_i,
  input logic [PTR_W-1:0]            ptr_i,
  input logic [LANES-1:0][CNT_W-1:0] cnt_i
);
  a_r2_rotate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i) |=> ptr_i == (($past(ptr_i) == PTR_W'(LANES - 1)) ? '0 : $past(ptr_i) + 1'b1));

  a_r8_hold_ptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && ready_i) |=> $stable(ptr_i));

  a_r8_full_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i[ptr_i] == CNT_W'(DEPTH)) |-> !ready_i);

  a_r9_blocked_warns: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> af_i);

  a_r6_bits_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!tick_i) |-> $stable(ser_i));

  a_r7_no_clk_full_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == 2'd0) |-> !ser_clk_i);

  for (genvar g = 0; g < LANES; g++) begin : g_cnt
    a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i[g] <= CNT_W'(DEPTH));
  end
endmodule

bind rr_lane_distributor rr_lane_distributor_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .rate_i   (rate_i),
  .valid_i  (valid_i),
  .ready_i  (ready_o),
  .af_i     (almost_full_o),
  .ser_i    (ser_data_o),
  .ser_clk_i(ser_clk_o),
  .tick_i   (tick),
  .ptr_i    (wr_lane),
  .cnt_i    (lane_cnt)
);

// File: tb/rr_lane_distributor_tb.sv
module rr_lane_distributor_tb;
  localparam int LANES = 8;
  localparam int DEPTH = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  rate_i = 2'd0;
  logic [43:0] word_i = '0;
  logic        valid_i = 1'b0;
  logic        ready_o, almost_full_o, ser_clk_o;
  logic [LANES-1:0] ser_data_o;

  int total = 0;
  int bad = 0;

  always #2 clk_i = ~clk_i;

  rr_lane_distributor u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rate_i(rate_i), .word_i(word_i), .valid_i(valid_i),
    .ready_o(ready_o), .almost_full_o(almost_full_o), .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o)
  );

  // ---------------- behavioural reference ----------------
  logic [5:0] t6 [32] = '{6'b100111, 6'b011101, 6'b101101, 6'b110001, 6'b110101, 6'b101001,
                          6'b011001, 6'b111000, 6'b111001, 6'b100101, 6'b010101, 6'b110100,
                          6'b001101, 6'b101100, 6'b011100, 6'b010111, 6'b011011, 6'b100011,
                          6'b010011, 6'b110010, 6'b001011, 6'b101010, 6'b011010, 6'b111010,
                          6'b110011, 6'b100110, 6'b010110, 6'b110110, 6'b001110, 6'b101110,
                          6'b011110, 6'b101011};
  logic [3:0] t4 [8] = '{4'b1011, 4'b1001, 4'b0101, 4'b1100, 4'b1101, 4'b1010, 4'b0110, 4'b1110};

  int          m_div, m_ptr, n_acc;
  bit          m_acc;
  logic [9:0]  m_sh [LANES];
  int          m_bc [LANES];
  int          m_bi [LANES];
  bit          m_rd [LANES];
  logic [43:0] q [LANES][$];

  function automatic int ones(input logic [9:0] v);
    int n = 0;
    for (int i = 0; i < 10; i++) n += v[i];
    return n;
  endfunction

  // returns {new disparity, symbol}
  function automatic logic [10:0] ref_enc(input logic [7:0] b, input bit k, input bit rd);
    logic [5:0] a; logic [3:0] f; bit rm; int x, y;
    if (k) return rd ? {1'b0, 10'b1100000101} : {1'b1, 10'b0011111010};
    x = b[4:0]; y = b[7:5];
    a = t6[x];
    if (rd && (ones({4'b0, a}) != 3 || x == 7)) a = ~a;
    rm = (ones({4'b0, a}) == 3) ? rd : ~rd;
    f = t4[y];
    if (y == 7 && ((!rm && (x == 17 || x == 18 || x == 20)) || (rm && (x == 11 || x == 13 || x == 14))))
      f = 4'b0111;
    if (rm && (ones({6'b0, f}) != 2 || y == 3)) f = ~f;
    return {(ones({6'b0, f}) == 2) ? rm : ~rm, a, f};
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_div = 0; m_ptr = 0; m_acc = 0;
      for (int l = 0; l < LANES; l++) begin
        m_sh[l] = '0; m_bc[l] = 9; m_bi[l] = 0; m_rd[l] = 0; q[l].delete();
      end
    end else begin
      int mask;
      bit tk;
      mask = (1 << rate_i) - 1;
      tk = ((m_div & mask) == mask);
      m_acc = valid_i && (q[m_ptr].size() < DEPTH);
      m_div = (m_div + 1) % 8;
      for (int l = 0; l < LANES; l++) begin
        if (tk) begin
          if (m_bc[l] == 9) begin
            logic [10:0] r;
            if (m_bi[l] == 0 && q[l].size() == 0) begin
              r = ref_enc(8'h00, 1'b1, m_rd[l]);
            end else begin
              logic [47:0] p;
              p = {4'b0, q[l][0]};
              r = ref_enc(p[47 - 8 * m_bi[l] -: 8], 1'b0, m_rd[l]);
              m_bi[l]++;
              if (m_bi[l] == 6) begin m_bi[l] = 0; void'(q[l].pop_front()); end
            end
            m_rd[l] = r[10]; m_sh[l] = r[9:0]; m_bc[l] = 0;
          end else begin
            m_sh[l] = m_sh[l] << 1; m_bc[l]++;
          end
        end
      end
      if (m_acc) begin
        q[m_ptr].push_back(word_i);
        m_ptr = (m_ptr + 1) % LANES;
        n_acc++;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    bit af_e;
    @(negedge clk_i);
    af_e = 0;
    for (int l = 0; l < LANES; l++) if (q[l].size() >= DEPTH - 1) af_e = 1;
    if (!rst_ni) begin
      chk("R1 ready", 64'(ready_o), 64'd1);
      chk("R1 almost_full", 64'(almost_full_o), 64'd0);
      chk("R1 ser", 64'(ser_data_o), 64'd0);
      chk("R1 ser_clk", 64'(ser_clk_o), 64'd0);
    end else begin
      chk("R8 ready", 64'(ready_o), 64'(q[m_ptr].size() < DEPTH));
      chk("R9 almost_full", 64'(almost_full_o), 64'(af_e));
      for (int l = 0; l < LANES; l++)
        chk($sformatf("R2,R3,R4,R5,R6 lane %0d", l), 64'(ser_data_o[l]), 64'(m_sh[l][9]));
      chk("R7 ser_clk", 64'(ser_clk_o), (rate_i == 0) ? 64'd0 : 64'((m_div >> (rate_i - 1)) & 1));
    end
  endtask

  task automatic do_reset(input logic [1:0] r);
    rst_ni = 1'b0; valid_i = 1'b0; rate_i = r;
    repeat (3) step();
    rst_ni = 1'b1;
    n_acc = 0;
  endtask

  function automatic logic [43:0] rnd_word();
    return {12'($urandom()), 32'($urandom())};
  endfunction

  task automatic send(input logic [43:0] w, input int gap);
    valid_i = 1'b1; word_i = w;
    do step(); while (!m_acc);
    valid_i = 1'b0;
    repeat (gap) step();
  endtask

  task automatic drain();
    bool_busy: forever begin
      bit busy = 0;
      for (int l = 0; l < LANES; l++) if (q[l].size() != 0 || m_bi[l] != 0) busy = 1;
      if (!busy) break;
      step();
    end
    repeat (24 << rate_i) step();
  endtask

  initial begin
    logic [9:0] cap;
    int first_block;

    // rate 0: first symbol is a negative-disparity comma, then a dense burst
    do_reset(2'd0);
    for (int i = 0; i < 10; i++) begin step(); cap[9 - i] = ser_data_o[0]; end
    chk("R5 first comma", 64'(cap), 64'b0011111010);
    send(44'h000_0000_0000, 0);
    send(44'hFFF_FFFF_FFFF, 0);
    send(44'hAAA_5555_AAAA, 0);
    send(44'h1F1_F1F1_7BFC, 0);
    for (int i = 0; i < 36; i++) send(rnd_word(), 0);
    drain();

    // rate 1: separate clock mode with gaps
    do_reset(2'd1);
    for (int i = 0; i < 24; i++) send(rnd_word(), $urandom_range(0, 3));
    drain();

    // rate 2
    do_reset(2'd2);
    for (int i = 0; i < 16; i++) send(rnd_word(), 0);
    drain();

    // rate 3: fill every buffer; R10 count before first backpressure
    do_reset(2'd3);
    first_block = -1;
    for (int i = 0; i < 40; i++) begin
      valid_i = 1'b1; word_i = rnd_word();
      forever begin
        step();
        if (m_acc) break;
        if (first_block < 0) first_block = n_acc;
      end
    end
    valid_i = 1'b0;
    chk("R10 accepted before stall", 64'(first_block), 64'(LANES * DEPTH));
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule